// File: doc/BRIEF.md
# RV32I Load/Store Execution Unit

This block carries out the integer load and store instructions of a 32-bit RISC-V core. The issue side hands it the raw instruction word together with the two source register values. The block works out what the instruction is and what address it touches. It then places one request on a word-addressed data memory port and, for loads, returns the extended result on a register writeback port.

Address and width faults are screened when the instruction is accepted. An instruction whose address does not suit its width, or whose width code is unused, never reaches memory. Instead, a one-cycle flag is raised for the trap logic outside the block. Opcodes other than load and store are accepted and dropped with no effect, so that a shared issue bus needs no separate filtering.

The memory port handles one request at a time. The request is held until the memory accepts it. For a load, the data word comes back on a separate valid strobe at least one cycle after the acceptance.

Top module: `ldst_unit`

## Requirements
- R1: Opcode 7'b0000011 (instr[6:0]) is a load and 7'b0100011 is a store. An accepted instruction with any other opcode produces no memory request, no flag and no writeback.
- R2: The byte address is op_rs1 plus the 12-bit immediate sign-extended to 32 bits. Loads take the immediate from instr[31:20]. The port carries the address as mem_word_addr = address[31:2].
- R3: For stores, the immediate is instr[31:25] as bits 11..5 followed by instr[11:7] as bits 4..0.
- R4: The width code is instr[14:12]. Stores use 000 byte, 001 halfword and 010 word. Lane = address[1:0], little-endian. mem_be has one bit per accessed byte: 4'b0001<<lane, 4'b0011<<lane or 4'b1111, for loads as well as stores. Store data is rs2[7:0] copied into all four lanes, rs2[15:0] copied into both halves, or all of rs2.
- R5: Load codes are 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte and 101 unsigned halfword. The returned word is shifted right by 8×lane. The low byte or halfword is then sign-extended or zero-extended as the code says; a word is passed unchanged.
- R6: A halfword access with address[0]=1, or a word access with address[1:0]≠0, raises flag_misaligned for one cycle and issues no request.
- R7: Load codes 011, 110 and 111, and store codes 011 and above, raise flag_illegal for one cycle and issue no request. This flag takes precedence over the misaligned flag.
- R8: After reset op_ready is high and no request, writeback or flag is active. A request appears in the cycle after acceptance, with op_ready low. It is held with stable address, enables, data and direction until mem_ready is seen high at a clock edge.
- R9: rd_we is high for exactly one cycle, in the cycle after the clock edge where mem_rvalid is seen for a pending load, with rd_idx = instr[11:7]. It is never raised for a store.
- R10: The word 32'h00462683 is a word load into rd 13 from op_rs1 + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| op_valid | input | 1 | Instruction offered for execution |
| op_ready | output | 1 | Unit idle; an offered instruction is taken at this edge |
| op_instr | input | 32 | Raw instruction word |
| op_rs1 | input | 32 | Base register value |
| op_rs2 | input | 32 | Store source register value |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_word_addr | output | 30 | Word address of the access |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_ready | input | 1 | Memory accepts the pending request |
| mem_rvalid | input | 1 | Load data word is valid |
| mem_rdata | input | 32 | Load data word |
| rd_we | output | 1 | Writeback strobe for the destination register |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Extended load result |
| flag_misaligned | output | 1 | One-cycle pulse: access not aligned to its width |
| flag_illegal | output | 1 | One-cycle pulse: unused width code |

## Verification
A clock edge that accepts an instruction sets up its memory request, or its fault flag, so both can be read one cycle later. A no-op opcode shows its absence of effect in that same cycle. Each request then stays in place through the wait cycles the bench inserts before mem_ready. The writeback result appears one cycle after the edge that sees mem_rvalid, and is gone one cycle after that. The bench drives every input shortly after a rising edge and reads every output at the following falling edge. Each check is therefore placed after the counted number of edges and never at an edge itself.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned NLANES    = XLEN / 8;
  localparam int unsigned LANE_W    = $clog2(NLANES);
  localparam int unsigned IMM_W     = 12;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned OPC_W     = 7;
  localparam int unsigned F3_W      = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } lsu_state_e;

  typedef struct packed {
    logic                 is_load;
    logic                 is_store;
    logic                 bad_width;
    logic                 misalign;
    acc_size_e            size;
    logic                 zext;
    logic [REG_IDX_W-1:0] rd;
    logic [XLEN-1:0]      ea;
  } dec_t;

endpackage

// File: rtl/ldst_rst_sync.sv
module ldst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs1_i,
  output dec_t            dec_o
);

  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;
  logic             ld, st;
  logic [IMM_W-1:0] imm12;
  logic [XLEN-1:0]  ea;
  acc_size_e        size;
  logic             unused_rs1_field;

  assign opc = instr_i[OPC_W-1:0];
  assign f3  = instr_i[14:12];
  assign ld  = (opc == OPC_LOAD);
  assign st  = (opc == OPC_STORE);
  assign unused_rs1_field = ^instr_i[19:15];

  // Store offsets are split around the rs2 field; load offsets are contiguous.
  always_comb begin
    if (st) imm12 = {instr_i[31:25], instr_i[11:7]};
    else    imm12 = instr_i[31:20];
  end

  assign ea   = rs1_i + {{(XLEN-IMM_W){imm12[IMM_W-1]}}, imm12};
  assign size = acc_size_e'(f3[1:0]);

  always_comb begin
    dec_o          = '0;
    dec_o.is_load  = ld;
    dec_o.is_store = st;
    dec_o.size     = size;
    dec_o.zext     = f3[2];
    dec_o.rd       = instr_i[11:7];
    dec_o.ea       = ea;
    // Loads allow 000,001,010,100,101; stores allow 000,001,010.
    if (ld)      dec_o.bad_width = (f3[1:0] == 2'b11) || (f3[2] && f3[1]);
    else if (st) dec_o.bad_width = f3[2] || (f3[1:0] == 2'b11);
    else         dec_o.bad_width = 1'b0;
    unique case (size)
      SZ_HALF: dec_o.misalign = ea[0];
      SZ_WORD: dec_o.misalign = (ea[LANE_W-1:0] != '0);
      default: dec_o.misalign = 1'b0;
    endcase
  end

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
  import ldst_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [XLEN-1:0]   data_i,
  output logic [NLANES-1:0] be_o,
  output logic [XLEN-1:0]   data_o
);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam logic [LANE_W-1:0] IDX = LANE_W'(i);

    logic hit_byte, hit_half;
    assign hit_byte = (lane_i == IDX);
    assign hit_half = (lane_i[LANE_W-1:1] == IDX[LANE_W-1:1]);

    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          be_o[i]         = hit_byte;
          data_o[8*i +: 8] = data_i[7:0];
        end
        SZ_HALF: begin
          be_o[i]         = hit_half;
          data_o[8*i +: 8] = data_i[8*(i%2) +: 8];
        end
        default: begin
          be_o[i]         = 1'b1;
          data_o[8*i +: 8] = data_i[8*i +: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
  import ldst_pkg::*;
(
  input  logic [XLEN-1:0]   word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  acc_size_e         size_i,
  input  logic              zext_i,
  output logic [XLEN-1:0]   value_o
);

  logic [XLEN-1:0] shifted;
  logic            fill_b, fill_h;

  assign shifted = word_i >> {lane_i, 3'b000};
  assign fill_b  = ~zext_i & shifted[7];
  assign fill_h  = ~zext_i & shifted[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(XLEN-8){fill_b}},  shifted[7:0]};
      SZ_HALF: value_o = {{(XLEN-16){fill_h}}, shifted[15:0]};
      default: value_o = shifted;
    endcase
  end

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [XLEN-1:0]        op_instr,
  input  logic [XLEN-1:0]        op_rs1,
  input  logic [XLEN-1:0]        op_rs2,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [XLEN-LANE_W-1:0] mem_word_addr,
  output logic [NLANES-1:0]      mem_be,
  output logic [XLEN-1:0]        mem_wdata,
  input  logic                   mem_ready,
  input  logic                   mem_rvalid,
  input  logic [XLEN-1:0]        mem_rdata,
  output logic                   rd_we,
  output logic [REG_IDX_W-1:0]   rd_idx,
  output logic [XLEN-1:0]        rd_data,
  output logic                   flag_misaligned,
  output logic                   flag_illegal
);

  localparam int unsigned WADDR_W = XLEN - LANE_W;

  logic rst_n_i;

  ldst_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_i)
  );

  // ---------------- issue-side decode and steering ----------------
  dec_t              dec;
  logic [NLANES-1:0] st_be;
  logic [XLEN-1:0]   st_data;

  ldst_decode u_dec (
    .instr_i (op_instr),
    .rs1_i   (op_rs1),
    .dec_o   (dec)
  );

  ldst_store_steer u_steer (
    .size_i (dec.size),
    .lane_i (dec.ea[LANE_W-1:0]),
    .data_i (op_rs2),
    .be_o   (st_be),
    .data_o (st_data)
  );

  // ---------------- control ----------------
  lsu_state_e state_q, state_d;
  logic       mem_op, accept, launch, fault_ill, fault_mis, capture_rd;

  assign mem_op     = dec.is_load | dec.is_store;
  assign accept     = op_valid && (state_q == ST_IDLE);
  assign fault_ill  = accept && mem_op && dec.bad_width;
  assign fault_mis  = accept && mem_op && !dec.bad_width && dec.misalign;
  assign launch     = accept && mem_op && !dec.bad_width && !dec.misalign;
  assign capture_rd = (state_q == ST_RESP) && mem_rvalid;

  // ---------------- request and return registers ----------------
  logic [WADDR_W-1:0]   addr_q;
  logic [NLANES-1:0]    be_q;
  logic [XLEN-1:0]      wdata_q;
  logic                 we_q;
  logic [LANE_W-1:0]    lane_q;
  acc_size_e            size_q;
  logic                 zext_q;
  logic [REG_IDX_W-1:0] rd_q;
  logic [XLEN-1:0]      rdat_q;
  logic                 wb_q, mis_q, ill_q;
  logic [XLEN-1:0]      ld_value;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch)     state_d = ST_REQ;
      ST_REQ:  if (mem_ready)  state_d = we_q ? ST_IDLE : ST_RESP;
      ST_RESP: if (mem_rvalid) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      lane_q  <= '0;
      size_q  <= SZ_BYTE;
      zext_q  <= 1'b0;
      rd_q    <= '0;
    end else if (launch) begin
      addr_q  <= dec.ea[XLEN-1:LANE_W];
      be_q    <= st_be;
      wdata_q <= st_data;
      we_q    <= dec.is_store;
      lane_q  <= dec.ea[LANE_W-1:0];
      size_q  <= dec.size;
      zext_q  <= dec.zext;
      rd_q    <= dec.rd;
    end
  end

  ldst_load_extend u_ext (
    .word_i  (mem_rdata),
    .lane_i  (lane_q),
    .size_i  (size_q),
    .zext_i  (zext_q),
    .value_o (ld_value)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)        rdat_q <= '0;
    else if (capture_rd) rdat_q <= ld_value;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wb_q  <= 1'b0;
      mis_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      wb_q  <= capture_rd;
      mis_q <= fault_mis;
      ill_q <= fault_ill;
    end
  end

  // ---------------- outputs ----------------
  assign op_ready        = (state_q == ST_IDLE);
  assign mem_req         = (state_q == ST_REQ);
  assign mem_we          = we_q;
  assign mem_word_addr   = addr_q;
  assign mem_be          = be_q;
  assign mem_wdata       = wdata_q;
  assign rd_we           = wb_q;
  assign rd_idx          = rd_q;
  assign rd_data         = rdat_q;
  assign flag_misaligned = mis_q;
  assign flag_illegal    = ill_q;

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
  import ldst_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_ready,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic [XLEN-LANE_W-1:0] mem_word_addr,
  input logic [NLANES-1:0]      mem_be,
  input logic [XLEN-1:0]        mem_wdata,
  input logic                   mem_ready,
  input logic                   mem_rvalid,
  input logic                   rd_we,
  input logic                   flag_misaligned,
  input logic                   flag_illegal
);

  // Tracks a load that has been accepted by memory and awaits its data.
  logic ld_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ld_pend_q <= 1'b0;
    else if (mem_req && mem_ready && !mem_we)  ld_pend_q <= 1'b1;
    else if (mem_rvalid)                       ld_pend_q <= 1'b0;
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_word_addr) && $stable(mem_be)
                              && $stable(mem_we) && $stable(mem_wdata));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready);

  p_wb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |=> !rd_we);

  p_wb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $past(ld_pend_q && mem_rvalid));

  p_store_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> !rd_we);

  p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2)
                || ($countones(mem_be) == NLANES));

  p_half_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && ($countones(mem_be) == 2) |-> (mem_be == 4'b0011) || (mem_be == 4'b1100));

  p_fault_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_misaligned || flag_illegal |-> !mem_req);

  p_one_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_misaligned && flag_illegal));

endmodule

bind ldst_unit ldst_unit_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_ready        (op_ready),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_word_addr   (mem_word_addr),
  .mem_be          (mem_be),
  .mem_wdata       (mem_wdata),
  .mem_ready       (mem_ready),
  .mem_rvalid      (mem_rvalid),
  .rd_we           (rd_we),
  .flag_misaligned (flag_misaligned),
  .flag_illegal    (flag_illegal)
);

// File: tb/sim_ldst_unit.sv
`timescale 1ns/1ps
module sim_ldst_unit;

  localparam int K_NONE = 0;
  localparam int K_REQ  = 1;
  localparam int K_MIS  = 2;
  localparam int K_ILL  = 3;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [3:0]  be;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] rd_val;
    logic [4:0]  rd;
    int          wr;
    int          wd;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [31:0] op_instr, op_rs1, op_rs2;
  logic        mem_req, mem_we;
  logic [29:0] mem_word_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ready, mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rd_we;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        flag_misaligned, flag_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  int pending = 0;
  item_t q[$];

  always #10 clk = ~clk;

  ldst_unit u0 (
    .clk (clk), .rst_n (rst_n),
    .op_valid (op_valid), .op_ready (op_ready),
    .op_instr (op_instr), .op_rs1 (op_rs1), .op_rs2 (op_rs2),
    .mem_req (mem_req), .mem_we (mem_we), .mem_word_addr (mem_word_addr),
    .mem_be (mem_be), .mem_wdata (mem_wdata),
    .mem_ready (mem_ready), .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
    .rd_we (rd_we), .rd_idx (rd_idx), .rd_data (rd_data),
    .flag_misaligned (flag_misaligned), .flag_illegal (flag_illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_ld(input logic [2:0] f3, input logic [4:0] rd, input logic [11:0] imm);
    return {imm, 5'd1, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_st(input logic [2:0] f3, input logic [11:0] imm);
    return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
  endfunction

  // Expected outcome built from the requirement text.
  function automatic item_t model(input logic [31:0] instr, input logic [31:0] rs1, input logic [31:0] rs2,
                                  input logic [31:0] rdata, input int wr, input int wd, input string tag);
    item_t it;
    logic [2:0]  f3;
    logic        ld, st;
    logic [11:0] imm;
    logic [31:0] ea, sh;
    int          nb;
    f3  = instr[14:12];
    ld  = (instr[6:0] == 7'b0000011);
    st  = (instr[6:0] == 7'b0100011);
    imm = st ? {instr[31:25], instr[11:7]} : instr[31:20];
    ea  = rs1 + {{20{imm[11]}}, imm};
    it.kind = K_REQ; it.addr = ea; it.we = st; it.rdata = rdata; it.rd = instr[11:7];
    it.wr = wr; it.wd = wd; it.tag = tag; it.be = 4'h0; it.wdata = 32'h0; it.rd_val = 32'h0;
    nb = (f3[1:0] == 2'd0) ? 1 : (f3[1:0] == 2'd1) ? 2 : 4;
    if (!ld && !st) it.kind = K_NONE;
    else if ((ld && (f3 == 3'd3 || f3 == 3'd6 || f3 == 3'd7)) || (st && f3 >= 3'd3)) it.kind = K_ILL;
    else if ((ea % nb) != 0) it.kind = K_MIS;
    else begin
      it.be    = ((nb == 1) ? 4'b0001 : (nb == 2) ? 4'b0011 : 4'b1111) << ea[1:0];
      it.wdata = (nb == 1) ? {4{rs2[7:0]}} : (nb == 2) ? {2{rs2[15:0]}} : rs2;
      sh = rdata >> (8 * ea[1:0]);
      case (f3)
        3'd0:    it.rd_val = {{24{sh[7]}}, sh[7:0]};
        3'd1:    it.rd_val = {{16{sh[15]}}, sh[15:0]};
        3'd4:    it.rd_val = {24'h0, sh[7:0]};
        3'd5:    it.rd_val = {16'h0, sh[15:0]};
        default: it.rd_val = sh;
      endcase
    end
    return it;
  endfunction

  // Driver: queue the expectation, offer the instruction, wait for the monitor.
  task automatic drive(input item_t it, input logic [31:0] instr, input logic [31:0] rs1, input logic [31:0] rs2);
    q.push_back(it);
    pending++;
    @(posedge clk); #2;
    op_valid = 1'b1; op_instr = instr; op_rs1 = rs1; op_rs2 = rs2;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    @(posedge clk); #2;
    op_valid = 1'b0;
    wait (pending == 0);
  endtask

  task automatic run(input logic [31:0] instr, input logic [31:0] rs1, input logic [31:0] rs2,
                     input logic [31:0] rdata, input int wr, input int wd, input string tag);
    drive(model(instr, rs1, rs2, rdata, wr, wd, tag), instr, rs1, rs2);
  endtask

  // Monitor / memory responder.
  initial begin : monitor
    item_t it;
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (rst_n && op_valid && op_ready && q.size() > 0) begin
        @(negedge clk);
        it = q.pop_front();
        chk(it.tag, "flag_misaligned", {31'h0, flag_misaligned}, {31'h0, it.kind == K_MIS});
        chk(it.tag, "flag_illegal",    {31'h0, flag_illegal},    {31'h0, it.kind == K_ILL});
        chk(it.tag, "mem_req",         {31'h0, mem_req},         {31'h0, it.kind == K_REQ});
        if (it.kind == K_REQ) begin
          chk("R8", "op_ready busy", {31'h0, op_ready}, 32'h0);
          chk(it.tag, "word addr", {2'b0, mem_word_addr}, {2'b0, it.addr[31:2]});
          chk(it.tag, "byte enables", {28'h0, mem_be}, {28'h0, it.be});
          chk(it.tag, "direction", {31'h0, mem_we}, {31'h0, it.we});
          if (it.we) chk(it.tag, "write data", mem_wdata, it.wdata);
          for (int w = 0; w < it.wr; w++) begin
            @(negedge clk);
            chk("R8", "request held", {31'h0, mem_req}, 32'h1);
            chk("R8", "addr held", {2'b0, mem_word_addr}, {2'b0, it.addr[31:2]});
          end
          @(posedge clk); #2; mem_ready = 1'b1;
          @(posedge clk); #2; mem_ready = 1'b0;
          if (!it.we) begin
            for (int w = 0; w < it.wd; w++) begin @(posedge clk); #2; end
            mem_rvalid = 1'b1; mem_rdata = it.rdata;
            @(posedge clk); #2;
            mem_rvalid = 1'b0; mem_rdata = 32'h5A5A5A5A;
            @(negedge clk);
            chk("R9", "rd_we pulse", {31'h0, rd_we}, 32'h1);
            chk(it.tag, "rd_data", rd_data, it.rd_val);
            chk("R9", "rd_idx", {27'h0, rd_idx}, {27'h0, it.rd});
            @(negedge clk);
            chk("R9", "rd_we single", {31'h0, rd_we}, 32'h0);
          end else begin
            @(negedge clk);
            chk("R9", "no wb after store", {31'h0, rd_we}, 32'h0);
            chk("R8", "req dropped", {31'h0, mem_req}, 32'h0);
            @(negedge clk);
            chk("R9", "no wb after store", {31'h0, rd_we}, 32'h0);
          end
        end else begin
          chk(it.tag, "no wb", {31'h0, rd_we}, 32'h0);
          @(negedge clk);
          chk(it.tag, "flags cleared", {30'h0, flag_misaligned, flag_illegal}, 32'h0);
          chk(it.tag, "still no req", {31'h0, mem_req}, 32'h0);
        end
        pending--;
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : stim
    item_t ex;
    rst_n = 1'b0; op_valid = 1'b0; op_instr = 32'h0; op_rs1 = 32'h0; op_rs2 = 32'h0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset op_ready", {31'h0, op_ready}, 32'h1);
    chk("R8", "reset mem_req",  {31'h0, mem_req},  32'h0);
    chk("R8", "reset rd_we",    {31'h0, rd_we},    32'h0);
    chk("R8", "reset flags",    {30'h0, flag_misaligned, flag_illegal}, 32'h0);

    // R10: fixed encoding, literal expectation.
    ex.kind = K_REQ; ex.addr = 32'h0000_1004; ex.be = 4'hF; ex.we = 1'b0; ex.wdata = 32'h0;
    ex.rdata = 32'hCAFE_0123; ex.rd_val = 32'hCAFE_0123; ex.rd = 5'd13; ex.wr = 1; ex.wd = 0; ex.tag = "R10";
    drive(ex, 32'h0046_2683, 32'h0000_1000, 32'h0);

    // R5: byte loads on every lane, signed and unsigned.
    for (int l = 0; l < 4; l++) run(enc_ld(3'd0, 5'd5, 12'(l)), 32'h0000_2000, 32'h0, 32'h80F1_7F22, l % 2, l, "R5");
    run(enc_ld(3'd4, 5'd6, 12'd3), 32'h0000_2000, 32'h0, 32'h80F1_7F22, 0, 1, "R5");
    run(enc_ld(3'd4, 5'd6, 12'd2), 32'h0000_2000, 32'h0, 32'h80F1_7F22, 0, 0, "R5");
    run(enc_ld(3'd1, 5'd7, 12'd2), 32'h0000_2000, 32'h0, 32'h80F1_7F22, 2, 0, "R5");
    run(enc_ld(3'd1, 5'd7, 12'd0), 32'h0000_2000, 32'h0, 32'h80F1_7F22, 0, 0, "R5");
    run(enc_ld(3'd5, 5'd8, 12'd2), 32'h0000_2000, 32'h0, 32'h80F1_7F22, 0, 2, "R5");
    run(enc_ld(3'd2, 5'd9, 12'd8), 32'h0000_2000, 32'h0, 32'h8000_0001, 3, 1, "R5");

    // R2: negative load offset crossing a word boundary.
    run(enc_ld(3'd2, 5'd10, 12'hFFC), 32'h0000_2000, 32'h0, 32'h1234_5678, 0, 0, "R2");
    run(enc_ld(3'd0, 5'd11, 12'h801), 32'h0001_0000, 32'h0, 32'h00AB_0000, 0, 0, "R2");

    // R3 / R4: store offsets from the split field, lane steering.
    run(enc_st(3'd0, 12'd1),     32'h0000_3000, 32'h1234_56AB, 32'h0, 0, 0, "R4");
    run(enc_st(3'd0, 12'd3),     32'h0000_3000, 32'h1234_56CD, 32'h0, 1, 0, "R4");
    run(enc_st(3'd1, 12'd2),     32'h0000_3000, 32'h1234_56AB, 32'h0, 2, 0, "R4");
    run(enc_st(3'd2, 12'd0),     32'h0000_3000, 32'hA5C3_0F96, 32'h0, 0, 0, "R4");
    run(enc_st(3'd2, 12'h7E4),   32'h0000_3000, 32'h0000_0001, 32'h0, 0, 0, "R3");
    run(enc_st(3'd1, 12'hFF6),   32'h0000_3000, 32'hFFFF_8001, 32'h0, 1, 0, "R3");
    run(enc_st(3'd0, 12'h03F),   32'h0000_3000, 32'h0000_0077, 32'h0, 0, 0, "R3");

    // R6: misaligned halfword and word accesses.
    run(enc_ld(3'd1, 5'd3, 12'd1), 32'h0000_4000, 32'h0, 32'h0, 0, 0, "R6");
    run(enc_ld(3'd2, 5'd3, 12'd2), 32'h0000_4000, 32'h0, 32'h0, 0, 0, "R6");
    run(enc_st(3'd2, 12'd3),       32'h0000_4000, 32'h0, 32'h0, 0, 0, "R6");
    run(enc_st(3'd1, 12'd1),       32'h0000_4002, 32'h0, 32'h0, 0, 0, "R6");

    // R7: unused width codes, with precedence over misalignment.
    run(enc_ld(3'd3, 5'd4, 12'd0), 32'h0000_5000, 32'h0, 32'h0, 0, 0, "R7");
    run(enc_ld(3'd6, 5'd4, 12'd0), 32'h0000_5000, 32'h0, 32'h0, 0, 0, "R7");
    run(enc_ld(3'd7, 5'd4, 12'd1), 32'h0000_5000, 32'h0, 32'h0, 0, 0, "R7");
    run(enc_st(3'd4, 12'd0),       32'h0000_5000, 32'h0, 32'h0, 0, 0, "R7");
    run(enc_st(3'd3, 12'd1),       32'h0000_5000, 32'h0, 32'h0, 0, 0, "R7");

    // R1: non-memory opcodes are dropped.
    run(32'h0020_81B3, 32'h0000_6000, 32'h1, 32'h0, 0, 0, "R1");
    run(32'h0000_0013, 32'h0000_6000, 32'h1, 32'h0, 0, 0, "R1");
    run(enc_ld(3'd2, 5'd1, 12'd4) ^ 32'h0000_0040, 32'h0000_6000, 32'h0, 32'h0, 0, 0, "R1");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule